// File: doc/BRIEF.md
# Clock and Signal Loss Monitor

This block supervises the receive side of a high-rate line interface. It watches the recovered receive clock and the byte stream taken before descrambling, and raises two alarms: loss of clock (LOC) and loss of signal (LOS). Everything runs on the always-running management clock. The monitored clock enters only as a sampled level, through a two-flop synchroniser. Receive bytes arrive with a per-byte valid strobe, so one valid byte stands for one byte time of the line.

LOC is raised when the synchronised monitored clock shows no edge for a parameterised number of management cycles. At the default of 2000 cycles at 200 MHz this is 10 µs. LOS is raised in two ways:

- An external alarm pin, which is synchronised first.
- An internal detector that finds a run of identical all-zero or all-one bytes as long as a programmable 11-bit window.

Once set, LOS clears only after the framer reports consecutive good framing patterns while neither cause is active. Each alarm has a state bit, a sticky delta bit and a mask bit. The masked deltas are combined into one registered interrupt line.

Top module: `clk_sig_mon`

## Requirements
- R1: `loc_state` rises once the synchronised `mon_clk` has shown no transition for LOC_LIMIT consecutive `clk` cycles. It falls within 5 cycles of transitions resuming.
- R2: A high level on `ext_los` sets `los_state` within 4 cycles. The pin passes through a two-flop synchroniser first.
- R3: A run of W consecutive valid bytes sets `los_state`, where W is the value of `los_window`. The bytes must be all 0x00 or all 0xFF. A run of W-1 such bytes does not set it. A window value of 0 acts as 1.
- R4: The run length restarts on any valid byte that holds both a 0 and a 1 bit. A uniform byte of the other polarity starts a new run of length 1. Cycles with `rx_valid` low neither extend nor break a run.
- R5: `los_state` clears only on the second consecutive `frm_strobe` with `frm_good` high while no LOS cause is active. A strobe with `frm_good` low restarts that count.
- R6: The clearing rule is the same for both causes. While the external pin is high, or the byte run has reached the window, good frames do not clear LOS.
- R7: `delta` bit 0 (LOC) and bit 1 (LOS) set on any change of the matching state bit. Each stays set until a 1 is written on the same bit of `delta_clr`. A new change in the same cycle as the clear wins.
- R8: `irq` is the registered OR of `delta & ~irq_mask`. A mask bit of 1 suppresses that alarm's contribution.
- R9: After synchronous reset, `loc_state`, `los_state`, `delta` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock, timebase for all logic |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Monitored receive clock, sampled as a level |
| rx_valid | input | 1 | Qualifies `rx_byte` for one byte time |
| rx_byte | input | 8 | Receive byte before descrambling |
| ext_los | input | 1 | External loss-of-signal alarm pin |
| frm_strobe | input | 1 | One-cycle pulse at each framing-pattern position |
| frm_good | input | 1 | Framing pattern correct, valid with `frm_strobe` |
| los_window | input | 11 | Run length in bytes for internal LOS |
| irq_mask | input | 2 | Per-alarm interrupt mask, 1 = masked |
| delta_clr | input | 2 | Write-one-to-clear pulses for `delta` |
| loc_state | output | 1 | Loss-of-clock state |
| los_state | output | 1 | Loss-of-signal state |
| delta | output | 2 | Sticky change bits, bit 0 LOC, bit 1 LOS |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives runs one byte shorter than the window and runs broken by a polarity flip. A detector that counts bytes regardless of polarity, or resets only on mixed bytes, would raise LOS there. It also aims at recovery:

- A bad frame between two good ones must not clear LOS. A design that counts good frames without requiring them to be consecutive would release LOS early.
- An active cause must hold LOS through good frames. A design that checks only framing would release LOS while the line is still dead.

Further cases cover the window extremes 0 and 2047, a stuck clock just below and just above the limit, and masking. An unmasked interrupt that stays quiet, or a delta that self-clears, shows up at once.

// File: rtl/clk_sig_mon_pkg.sv
package clk_sig_mon_pkg;
  localparam int ALM_LOC = 0;
  localparam int ALM_LOS = 1;
  localparam int ALM_N   = 2;
endpackage

// File: rtl/cs_sync2.sv
module cs_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cs_loc_det.sv
module cs_loc_det #(
  parameter int LOC_LIMIT = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_s,
  output logic loc
);
  localparam int CW = $clog2(LOC_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LOC_LIMIT);

  logic          mon_q;
  logic [CW-1:0] idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_q <= 1'b0;
      idle  <= '0;
      loc   <= 1'b0;
    end else begin
      mon_q <= mon_s;
      if (mon_s != mon_q) begin
        idle <= '0;
        loc  <= 1'b0;
      end else begin
        if (idle != LIM) idle <= idle + 1'b1;
        loc <= (idle == LIM);
      end
    end
  end
endmodule

// File: rtl/cs_run_det.sv
module cs_run_det #(
  parameter int DW    = 8,
  parameter int WIN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [DW-1:0]    data,
  input  logic [WIN_W-1:0] window,
  output logic             hit
);
  localparam logic [WIN_W-1:0] CMAX = '1;

  logic [WIN_W-1:0] run_len;
  logic             pol;
  logic             uniform;
  logic [WIN_W-1:0] win_eff;

  assign uniform = (data == '0) || (data == '1);
  assign win_eff = (window == '0) ? WIN_W'(1) : window;
  assign hit     = (run_len != '0) && (run_len >= win_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      pol     <= 1'b0;
    end else if (valid) begin
      if (!uniform) begin
        run_len <= '0;
      end else if (run_len == '0 || data[0] != pol) begin
        run_len <= WIN_W'(1);
        pol     <= data[0];
      end else if (run_len != CMAX) begin
        run_len <= run_len + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cs_los_ctrl.sv
module cs_los_ctrl #(
  parameter int FRM_NEED = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_s,
  input  logic run_hit,
  input  logic frm_strobe,
  input  logic frm_good,
  output logic los
);
  localparam int FW = $clog2(FRM_NEED + 1);
  localparam logic [FW-1:0] LAST = FW'(FRM_NEED - 1);

  logic [FW-1:0] good_cnt;
  logic          cause;

  assign cause = ext_s | run_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      los      <= 1'b0;
      good_cnt <= '0;
    end else if (cause) begin
      los      <= 1'b1;
      good_cnt <= '0;
    end else if (los && frm_strobe) begin
      if (!frm_good) begin
        good_cnt <= '0;
      end else if (good_cnt == LAST) begin
        los      <= 1'b0;
        good_cnt <= '0;
      end else begin
        good_cnt <= good_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cs_alarm_reg.sv
module cs_alarm_reg #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] st,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] delta,
  output logic         irq
);
  logic [N-1:0] st_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[i]  <= 1'b0;
        delta[i] <= 1'b0;
      end else begin
        st_q[i]  <= st[i];
        delta[i] <= (st[i] ^ st_q[i]) | (delta[i] & ~clr[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(delta & ~mask);
  end
endmodule

// File: rtl/clk_sig_mon.sv
module clk_sig_mon
  import clk_sig_mon_pkg::*;
#(
  parameter int LOC_LIMIT = 2000,
  parameter int DW        = 8,
  parameter int WIN_W     = 11,
  parameter int FRM_NEED  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mon_clk,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_byte,
  input  logic             ext_los,
  input  logic             frm_strobe,
  input  logic             frm_good,
  input  logic [WIN_W-1:0] los_window,
  input  logic [ALM_N-1:0] irq_mask,
  input  logic [ALM_N-1:0] delta_clr,
  output logic             loc_state,
  output logic             los_state,
  output logic [ALM_N-1:0] delta,
  output logic             irq
);
  logic [1:0]       sync_q;
  logic             mon_s;
  logic             ext_s;
  logic             run_hit;
  logic [ALM_N-1:0] st;

  cs_sync2 #(.WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .d({ext_los, mon_clk}), .q(sync_q)
  );
  assign mon_s = sync_q[0];
  assign ext_s = sync_q[1];

  cs_loc_det #(.LOC_LIMIT(LOC_LIMIT)) u_loc (
    .clk(clk), .rst(rst), .mon_s(mon_s), .loc(loc_state)
  );

  cs_run_det #(.DW(DW), .WIN_W(WIN_W)) u_run (
    .clk(clk), .rst(rst), .valid(rx_valid), .data(rx_byte),
    .window(los_window), .hit(run_hit)
  );

  cs_los_ctrl #(.FRM_NEED(FRM_NEED)) u_los (
    .clk(clk), .rst(rst), .ext_s(ext_s), .run_hit(run_hit),
    .frm_strobe(frm_strobe), .frm_good(frm_good), .los(los_state)
  );

  always_comb begin
    st          = '0;
    st[ALM_LOC] = loc_state;
    st[ALM_LOS] = los_state;
  end

  cs_alarm_reg #(.N(ALM_N)) u_alm (
    .clk(clk), .rst(rst), .st(st), .clr(delta_clr), .mask(irq_mask),
    .delta(delta), .irq(irq)
  );
endmodule

// File: rtl/clk_sig_mon_chk.sv
module clk_sig_mon_chk (
  input logic       clk,
  input logic       rst,
  input logic       ext_s,
  input logic       los_state,
  input logic       loc_state,
  input logic       frm_strobe,
  input logic       frm_good,
  input logic [1:0] delta,
  input logic [1:0] delta_clr,
  input logic       irq
);
  // R2
  ext_sets_los_chk: assert property (@(posedge clk) disable iff (rst)
    ext_s |=> los_state);

  // R5
  los_clear_needs_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(los_state) |-> $past(frm_strobe && frm_good));

  // R7
  delta0_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (delta[0] && !delta_clr[0]) |=> delta[0]);

  // R7
  delta1_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (delta[1] && !delta_clr[1]) |=> delta[1]);

  // R7
  los_change_delta_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(los_state) |=> delta[1]);

  // R7
  loc_change_delta_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(loc_state) |=> delta[0]);

  // R8
  quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (delta == 2'b00) |=> !irq);
endmodule

bind clk_sig_mon clk_sig_mon_chk u_chk (
  .clk(clk), .rst(rst), .ext_s(ext_s), .los_state(los_state),
  .loc_state(loc_state), .frm_strobe(frm_strobe), .frm_good(frm_good),
  .delta(delta), .delta_clr(delta_clr), .irq(irq)
);

// File: tb/tb_clk_sig_mon.sv
`timescale 1ns/1ps
module tb_clk_sig_mon;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mon_clk = 1'b0;
  logic        mon_run = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'hA5;
  logic        ext_los = 1'b0;
  logic        frm_strobe = 1'b0;
  logic        frm_good = 1'b0;
  logic [10:0] los_window = 11'd5;
  logic [1:0]  irq_mask = 2'b00;
  logic [1:0]  delta_clr = 2'b00;
  logic        loc_state, los_state, irq;
  logic [1:0]  delta;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      repeat (4) @(negedge clk);
      if (mon_run) mon_clk = ~mon_clk;
    end
  end

  clk_sig_mon dut (
    .clk(clk), .rst(rst), .mon_clk(mon_clk), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .ext_los(ext_los), .frm_strobe(frm_strobe),
    .frm_good(frm_good), .los_window(los_window), .irq_mask(irq_mask),
    .delta_clr(delta_clr), .loc_state(loc_state), .los_state(los_state),
    .delta(delta), .irq(irq)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic feed(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_byte = 8'hA5;
  endtask

  task automatic frame(input logic good);
    frm_strobe = 1'b1; frm_good = good;
    @(negedge clk);
    frm_strobe = 1'b0; frm_good = 1'b0;
    wait_n(2);
  endtask

  task automatic clear_all();
    delta_clr = 2'b11;
    @(negedge clk);
    delta_clr = 2'b00;
    wait_n(3);
  endtask

  task automatic t_reset();
    wait_n(3);
    chk("R9 loc", {3'b0, loc_state}, 4'h0);
    chk("R9 los", {3'b0, los_state}, 4'h0);
    chk("R9 delta", {2'b0, delta}, 4'h0);
    chk("R9 irq", {3'b0, irq}, 4'h0);
  endtask

  task automatic t_ext();
    ext_los = 1'b1;
    wait_n(4);
    chk("R2 ext sets los", {3'b0, los_state}, 4'h1);
    wait_n(2);
    chk("R7 los delta", {2'b0, delta}, 4'h2);
    chk("R8 irq unmasked", {3'b0, irq}, 4'h1);
    frame(1'b1); frame(1'b1);
    chk("R6 ext held blocks clear", {3'b0, los_state}, 4'h1);
    ext_los = 1'b0;
    wait_n(4);
    chk("R5 los holds after pin drops", {3'b0, los_state}, 4'h1);
    frame(1'b1);
    chk("R5 one good frame", {3'b0, los_state}, 4'h1);
    frame(1'b1);
    chk("R5 two good frames clear", {3'b0, los_state}, 4'h0);
    chk("R7 delta sticky", {2'b0, delta}, 4'h2);
    clear_all();
    chk("R7 delta cleared", {2'b0, delta}, 4'h0);
    chk("R8 irq drops", {3'b0, irq}, 4'h0);
  endtask

  task automatic t_bad_frame();
    ext_los = 1'b1; wait_n(4); ext_los = 1'b0; wait_n(4);
    frame(1'b1); frame(1'b0); frame(1'b1);
    chk("R5 bad frame restarts count", {3'b0, los_state}, 4'h1);
    frame(1'b1);
    chk("R5 clear after restart", {3'b0, los_state}, 4'h0);
    clear_all();
  endtask

  task automatic t_run();
    los_window = 11'd5;
    feed(8'h00, 4); feed(8'h3C, 1); wait_n(4);
    chk("R3 short run no los", {3'b0, los_state}, 4'h0);
    feed(8'h00, 4); feed(8'hFF, 4); wait_n(4);
    chk("R4 polarity flip restarts", {3'b0, los_state}, 4'h0);
    feed(8'h00, 3); wait_n(3); feed(8'h00, 1); feed(8'h3C, 1); wait_n(4);
    chk("R4 idle cycles keep run", {3'b0, los_state}, 4'h0);
    feed(8'h00, 3); feed(8'hFF, 5); wait_n(4);
    chk("R3 full run of ones sets los", {3'b0, los_state}, 4'h1);
    frame(1'b1); frame(1'b1);
    chk("R6 active run blocks clear", {3'b0, los_state}, 4'h1);
    feed(8'h81, 1); wait_n(2);
    frame(1'b1); frame(1'b1);
    chk("R6 run ended then clear", {3'b0, los_state}, 4'h0);
    clear_all();
    feed(8'h00, 2); wait_n(1); feed(8'h00, 3); wait_n(4);
    chk("R4 gaps do not break run", {3'b0, los_state}, 4'h1);
    feed(8'h7E, 1); wait_n(2); frame(1'b1); frame(1'b1); clear_all();
  endtask

  task automatic t_window_edges();
    los_window = 11'd0;
    feed(8'hFF, 1); wait_n(4);
    chk("R3 window 0 acts as 1", {3'b0, los_state}, 4'h1);
    feed(8'h12, 1); wait_n(2); frame(1'b1); frame(1'b1); clear_all();
    los_window = 11'd2047;
    feed(8'h00, 2046); feed(8'h18, 1); wait_n(4);
    chk("R3 max window minus one", {3'b0, los_state}, 4'h0);
    feed(8'h00, 2047); wait_n(4);
    chk("R3 max window reached", {3'b0, los_state}, 4'h1);
    feed(8'h18, 1); wait_n(2); frame(1'b1); frame(1'b1); clear_all();
    los_window = 11'd5;
  endtask

  task automatic t_mask();
    irq_mask = 2'b10;
    ext_los = 1'b1; wait_n(6);
    chk("R8 masked delta set", {2'b0, delta}, 4'h2);
    chk("R8 masked irq quiet", {3'b0, irq}, 4'h0);
    irq_mask = 2'b00; wait_n(2);
    chk("R8 unmask raises irq", {3'b0, irq}, 4'h1);
    ext_los = 1'b0; wait_n(4); frame(1'b1); frame(1'b1); clear_all();
  endtask

  task automatic t_loc();
    mon_run = 1'b0;
    wait_n(1500);
    chk("R1 below limit no loc", {3'b0, loc_state}, 4'h0);
    wait_n(700);
    chk("R1 stuck clock loc", {3'b0, loc_state}, 4'h1);
    chk("R7 loc delta", {2'b0, delta}, 4'h1);
    mon_run = 1'b1;
    wait_n(10);
    chk("R1 loc clears", {3'b0, loc_state}, 4'h0);
    clear_all();
    chk("R7 loc delta cleared", {2'b0, delta}, 4'h0);
  endtask

  initial begin
    wait_n(4);
    rst = 1'b0;
    t_reset();
    t_ext();
    t_bad_frame();
    t_run();
    t_window_edges();
    t_mask();
    t_loc();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule